// File: doc/BRIEF.md
# DLL Power-Up Lock Sequencer

This block brings a delay-locked loop up to a locked state after the card clock has been moved to a high rate. A one-cycle start pulse comes with the new clock rate. The sequencer accepts that pulse only when the rate differs from the last rate it was given and is above a fixed threshold. It then edits a 32-bit configuration word for the DLL in three steps, and waits a settle time after each step. First it clears the loop enable and the compensation enables. Next it sets the compensation enables, the search mode, the initial count field and the internal phase field. Last it sets the loop enable.

After the third settle time the sequencer samples the lock status input at a fixed poll interval. When lock is seen it pulses a done output. When the poll window runs out first it pulses done and raises a sticky lock-fail flag. All wait times are derived from a clock-frequency parameter in kHz and durations given in microseconds. The delay line itself sits outside the block.

Top module: `dll_lock_seq`

## Requirements
- R1: After synchronous reset `cfg_word` is 0, `seq_done` is 0 and `lock_fail` is 0.
- R2: A `start_req` is accepted only while idle, only when `rate_in` is greater than `RATE_THRESH` (default 52,000,000), and only when `rate_in` differs from the rate carried by the previous `start_req` seen while idle (0 after reset). Any other start leaves every output unchanged.
- R3: On the clock edge that accepts a start, `cfg_word` bit 21 (loop enable) and bits 18, 24, 25, 26 and 27 (compensation enables) are cleared. All other bits keep their values.
- R4: SETTLE cycles after acceptance, bits 18 and 24–27 are set, bit 16 (search mode) is set, the value 0xC00 is ORed in (bits 11:10), and 0x3 is ORed in (bits 1:0).
- R5: 2·SETTLE cycles after acceptance, bit 21 is set. Bit 21 is never 1 while a compensation bit is 0.
- R6: `lock_in` is first sampled on the edge 3·SETTLE+1 cycles after acceptance, and then every POLL cycles.
- R7: When `lock_in` is 1 at a sample, `seq_done` is 1 for exactly one cycle, starting after that edge. `lock_fail` stays 0 and the block returns to idle.
- R8: When sample number TIMEOUT_US/POLL_US (counting from 0) still sees no lock, `seq_done` pulses once on that edge and `lock_fail` rises with it. `lock_fail` stays high until the next accepted start clears it.
- R9: A `start_req` that arrives while a sequence is running is ignored. It neither restarts the sequence nor changes the remembered rate.
- R10: SETTLE = CLK_KHZ·SETTLE_US/1000 cycles and POLL = CLK_KHZ·POLL_US/1000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request after a card clock change |
| rate_in | input | RATE_W | New card clock rate in Hz, valid with start_req |
| lock_in | input | 1 | Lock status from the DLL |
| cfg_word | output | 32 | DLL configuration word (bit positions per R3–R5) |
| seq_done | output | 1 | One-cycle pulse when a sequence ends |
| lock_fail | output | 1 | Sticky flag: the last sequence timed out |

## Verification
The bench aims at the places where sequencers of this kind usually go wrong. A rate at or below the threshold, or a rate repeated from the last request, must leave the word untouched; a design that skipped either test would start a sequence. A second sequence must clear only the enable and compensation bits and keep search, count and phase set; a design that reset the whole word would show 0x00000000 instead of 0x00010C03. The bench also checks the poll sample times on a late lock and the exact last sample before timeout. An off-by-one poll count shifts `seq_done` by one POLL interval. Finally, a start issued mid-sequence must change neither the finish time nor the remembered rate.

// File: rtl/dls_pkg.sv
package dls_pkg;

  localparam int CFG_W = 32;

  localparam logic [CFG_W-1:0] DLS_COMP_MASK   = (32'h1 << 18) | (32'hF << 24);
  localparam logic [CFG_W-1:0] DLS_ENABLE_MASK = 32'h1 << 21;
  localparam logic [CFG_W-1:0] DLS_SEARCH_MASK = 32'h1 << 16;
  localparam logic [CFG_W-1:0] DLS_INIT_COUNT  = 32'h0000_0C00;
  localparam logic [CFG_W-1:0] DLS_PHASE_SEL   = 32'h0000_0003;
  localparam logic [CFG_W-1:0] DLS_STEP1_CLR   = DLS_COMP_MASK | DLS_ENABLE_MASK;
  localparam logic [CFG_W-1:0] DLS_STEP2_SET   = DLS_COMP_MASK | DLS_SEARCH_MASK |
                                                 DLS_INIT_COUNT | DLS_PHASE_SEL;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_SETTLE1,
    SEQ_SETTLE2,
    SEQ_SETTLE3,
    SEQ_POLL
  } seq_state_t;

  typedef enum logic [1:0] {
    CFG_HOLD,
    CFG_CLEAR,
    CFG_PREP,
    CFG_ENABLE
  } cfg_op_t;

endpackage

// File: rtl/dls_rate_gate.sv
module dls_rate_gate #(
  parameter int          RATE_W      = 32,
  parameter logic [31:0] RATE_THRESH = 32'd52_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle,
  input  logic              start_req,
  input  logic [RATE_W-1:0] rate_in,
  output logic              go
);

  logic [RATE_W-1:0] last_rate_q;
  logic              above;
  logic              changed;

  assign above   = rate_in > RATE_W'(RATE_THRESH);
  assign changed = rate_in != last_rate_q;
  assign go      = idle && start_req && above && changed;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_rate_q <= '0;
    end else if (idle && start_req) begin
      last_rate_q <= rate_in;
    end
  end

endmodule

// File: rtl/dls_tick_timer.sv
module dls_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dls_cfg_reg.sv
module dls_cfg_reg
  import dls_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  cfg_op_t          op,
  output logic [CFG_W-1:0] cfg_q
);

  logic [CFG_W-1:0] cfg_n;

  always_comb begin
    cfg_n = cfg_q;
    unique case (op)
      CFG_CLEAR:  cfg_n = cfg_q & ~DLS_STEP1_CLR;
      CFG_PREP:   cfg_n = cfg_q | DLS_STEP2_SET;
      CFG_ENABLE: cfg_n = cfg_q | DLS_ENABLE_MASK;
      default:    cfg_n = cfg_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_n;
  end

endmodule

// File: rtl/dll_lock_seq.sv
module dll_lock_seq
  import dls_pkg::*;
#(
  parameter int          CLK_KHZ     = 100_000,
  parameter int          SETTLE_US   = 1000,
  parameter int          POLL_US     = 2000,
  parameter int          TIMEOUT_US  = 1_000_000,
  parameter int          RATE_W      = 32,
  parameter logic [31:0] RATE_THRESH = 32'd52_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [RATE_W-1:0] rate_in,
  input  logic              lock_in,
  output logic [31:0]       cfg_word,
  output logic              seq_done,
  output logic              lock_fail
);

  localparam int SETTLE_CYC = CLK_KHZ * SETTLE_US / 1000;
  localparam int POLL_CYC   = CLK_KHZ * POLL_US / 1000;
  localparam int NUM_POLL   = TIMEOUT_US / POLL_US;
  localparam int MAX_WAIT   = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int TMR_W      = $clog2(MAX_WAIT + 1);
  localparam int IDX_W      = $clog2(NUM_POLL + 1);

  localparam logic [TMR_W-1:0] SETTLE_LOAD = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] POLL_LOAD   = TMR_W'(POLL_CYC - 1);
  localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(NUM_POLL);

  seq_state_t       state_q, state_n;
  cfg_op_t          cfg_op;
  logic             go;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_zero;
  logic [IDX_W-1:0] poll_idx_q;
  logic             idx_clr, idx_inc;
  logic             done_n, fail_set, fail_clr;
  logic             done_q, fail_q;

  dls_rate_gate #(
    .RATE_W      (RATE_W),
    .RATE_THRESH (RATE_THRESH)
  ) u_gate (
    .clk       (clk),
    .rst       (rst),
    .idle      (state_q == SEQ_IDLE),
    .start_req (start_req),
    .rate_in   (rate_in),
    .go        (go)
  );

  dls_tick_timer #(
    .CNT_W (TMR_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  dls_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .op    (cfg_op),
    .cfg_q (cfg_word)
  );

  always_comb begin
    state_n  = state_q;
    cfg_op   = CFG_HOLD;
    tmr_load = 1'b0;
    tmr_val  = SETTLE_LOAD;
    idx_clr  = 1'b0;
    idx_inc  = 1'b0;
    done_n   = 1'b0;
    fail_set = 1'b0;
    fail_clr = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (go) begin
          cfg_op   = CFG_CLEAR;
          tmr_load = 1'b1;
          idx_clr  = 1'b1;
          fail_clr = 1'b1;
          state_n  = SEQ_SETTLE1;
        end
      end
      SEQ_SETTLE1: begin
        if (tmr_zero) begin
          cfg_op   = CFG_PREP;
          tmr_load = 1'b1;
          state_n  = SEQ_SETTLE2;
        end
      end
      SEQ_SETTLE2: begin
        if (tmr_zero) begin
          cfg_op   = CFG_ENABLE;
          tmr_load = 1'b1;
          state_n  = SEQ_SETTLE3;
        end
      end
      SEQ_SETTLE3: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = '0;
          state_n  = SEQ_POLL;
        end
      end
      SEQ_POLL: begin
        if (tmr_zero) begin
          if (lock_in) begin
            done_n  = 1'b1;
            state_n = SEQ_IDLE;
          end else if (poll_idx_q == LAST_IDX) begin
            done_n   = 1'b1;
            fail_set = 1'b1;
            state_n  = SEQ_IDLE;
          end else begin
            idx_inc  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = POLL_LOAD;
          end
        end
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      poll_idx_q <= '0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      if (idx_clr)      poll_idx_q <= '0;
      else if (idx_inc) poll_idx_q <= poll_idx_q + 1'b1;
      if (fail_clr)      fail_q <= 1'b0;
      else if (fail_set) fail_q <= 1'b1;
    end
  end

  assign seq_done  = done_q;
  assign lock_fail = fail_q;

endmodule

// File: rtl/dll_lock_seq_chk.sv
module dll_lock_seq_chk
  import dls_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] cfg_word,
  input logic        seq_done,
  input logic        lock_fail
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done); // R7

  AST_ENABLE_NEEDS_COMP: assert property (@(posedge clk) disable iff (rst)
    cfg_word[21] |-> ((cfg_word & DLS_COMP_MASK) == DLS_COMP_MASK)); // R5

  AST_COMP_NEEDS_PREP: assert property (@(posedge clk) disable iff (rst)
    ((cfg_word & DLS_COMP_MASK) != '0) |->
      (cfg_word[16] && cfg_word[11:10] == 2'b11 && cfg_word[1:0] == 2'b11)); // R4

  AST_STEP1_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_word[21]) |-> ((cfg_word & DLS_COMP_MASK) == '0)); // R3

  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_fail) |-> seq_done); // R8

endmodule

bind dll_lock_seq dll_lock_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_word  (cfg_word),
  .seq_done  (seq_done),
  .lock_fail (lock_fail)
);

// File: tb/dll_lock_seq_tb.sv
module dll_lock_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int S_CYC  = 20;   // 1000 kHz * 20 us
  localparam int P_CYC  = 40;   // 1000 kHz * 40 us
  localparam int N_POLL = 10;   // 400 us / 40 us
  localparam logic [31:0] COMP = 32'h0F04_0000;
  localparam logic [31:0] EN   = 32'h0020_0000;
  localparam logic [31:0] PREP = 32'h0F05_0C03;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_req = 1'b0;
  logic [31:0] rate_in = '0;
  logic        lock_in = 1'b0;
  logic [31:0] cfg_word;
  logic        seq_done;
  logic        lock_fail;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dll_lock_seq #(
    .CLK_KHZ    (1000),
    .SETTLE_US  (20),
    .POLL_US    (40),
    .TIMEOUT_US (400)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .rate_in   (rate_in),
    .lock_in   (lock_in),
    .cfg_word  (cfg_word),
    .seq_done  (seq_done),
    .lock_fail (lock_fail)
  );

  // DLL stand-in: locks lock_dly cycles after enable unless broken
  bit broken = 0;
  int lock_dly = 5;
  int lcnt = 0;
  always @(negedge clk) begin
    if (broken || !cfg_word[21]) begin
      lcnt = 0;
      lock_in = 1'b0;
    end else begin
      lcnt = lcnt + 1;
      lock_in = (lcnt >= lock_dly);
    end
  end

  // Behavioural reference: elapsed-cycle view of a sequence
  logic [31:0] m_cfg;
  logic        m_done, m_fail;
  bit          m_busy;
  int          m_e, m_acc;
  logic [31:0] m_last;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      m_cfg = '0; m_done = 0; m_fail = 0; m_busy = 0; m_e = 0; m_last = '0; m_acc = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_req && rate_in > 32'd52_000_000 && rate_in != m_last) begin
          m_busy = 1; m_e = 0; m_acc = cyc; m_fail = 0;
          m_cfg = m_cfg & ~(COMP | EN);
        end
        if (start_req) m_last = rate_in;
      end else begin
        m_e = m_e + 1;
        if (m_e == S_CYC)     m_cfg = m_cfg | PREP;
        if (m_e == 2 * S_CYC) m_cfg = m_cfg | EN;
        if (m_e >= 3 * S_CYC + 1 && (m_e - 3 * S_CYC - 1) % P_CYC == 0) begin
          if (lock_in) begin
            m_done = 1; m_busy = 0;
          end else if ((m_e - 3 * S_CYC - 1) / P_CYC == N_POLL) begin
            m_done = 1; m_fail = 1; m_busy = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks += 3;
      if (cfg_word !== m_cfg) begin
        errors++;
        $display("FAIL R3 R4 R5 cfg_word at cycle %0d: actual %h expected %h", cyc, cfg_word, m_cfg);
      end
      if (seq_done !== m_done) begin
        errors++;
        $display("FAIL R6 R7 seq_done at cycle %0d: actual %b expected %b", cyc, seq_done, m_done);
      end
      if (lock_fail !== m_fail) begin
        errors++;
        $display("FAIL R8 lock_fail at cycle %0d: actual %b expected %b", cyc, lock_fail, m_fail);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [31:0] r);
    @(negedge clk); start_req = 1'b1; rate_in = r;
    @(negedge clk); start_req = 1'b0;
  endtask

  int dones;
  int lat;
  task automatic wait_done(input int max_cyc);
    dones = 0; lat = -1;
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge clk);
      if (seq_done) begin dones++; lat = cyc - m_acc; break; end
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset cfg_word", cfg_word, 32'h0);
    check("R1 reset seq_done", {31'b0, seq_done}, 32'h0);
    check("R1 reset lock_fail", {31'b0, lock_fail}, 32'h0);

    // R2: rate at threshold and below is ignored
    pulse_start(32'd52_000_000);
    pulse_start(32'd40_000_000);
    wait_done(30);
    check("R2 low rate no done", dones, 0);
    check("R2 low rate cfg untouched", cfg_word, 32'h0);

    // Fast lock: first sample succeeds
    lock_dly = 5;
    pulse_start(32'd100_000_000);
    check("R3 step1 from reset", cfg_word, 32'h0);
    repeat (S_CYC) @(negedge clk);
    check("R4 step2 value", cfg_word, PREP);
    repeat (S_CYC) @(negedge clk);
    check("R5 step3 value", cfg_word, PREP | EN);
    wait_done(200);
    check("R6 R7 R10 first-sample latency", lat, 3 * S_CYC + 1);
    @(negedge clk);
    check("R7 done one cycle", {31'b0, seq_done}, 32'h0);
    check("R7 no fail", {31'b0, lock_fail}, 32'h0);

    // R2: same rate again is ignored
    pulse_start(32'd100_000_000);
    wait_done(40);
    check("R2 repeated rate ignored", dones, 0);
    check("R2 repeated rate cfg kept", cfg_word, PREP | EN);

    // Timeout, with an ignored mid-sequence start (R9)
    broken = 1;
    pulse_start(32'd200_000_000);
    repeat (50) @(negedge clk);
    pulse_start(32'd300_000_000);
    wait_done(700);
    check("R8 R9 timeout latency", lat, 3 * S_CYC + 1 + N_POLL * P_CYC);
    check("R8 fail raised", {31'b0, lock_fail}, 32'h1);
    repeat (5) @(negedge clk);
    check("R8 fail sticky", {31'b0, lock_fail}, 32'h1);

    // Late lock; 300 MHz accepted since the mid-run start was ignored (R9)
    broken = 0;
    lock_dly = S_CYC + 60;
    pulse_start(32'd300_000_000);
    check("R3 R9 step1 keeps prep bits", cfg_word, 32'h0001_0C03);
    check("R8 fail cleared on start", {31'b0, lock_fail}, 32'h0);
    wait_done(400);
    check("R6 late lock third sample", lat, 3 * S_CYC + 1 + 2 * P_CYC);
    check("R7 late lock no fail", {31'b0, lock_fail}, 32'h0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule